// File: doc/BRIEF.md
# Round-Robin Bus Master Arbiter

This block decides which of three requesters owns a shared management bus: a host CPU, the local primary switch device and a remote secondary switch device. Each requester has its own request line. The arbiter names one owner at a time and delivers a grant whose form depends on the owner. The secondary device gets an external grant together with an active-low chip-select. The primary device gets only an internal grant, which feeds its bus master state machine. The CPU gets a plain grant.

Ownership rotates in the fixed order primary, secondary, CPU. An owner keeps the bus for as long as it keeps requesting. When it lets go, the bus stays free for exactly one cycle, and then the next requester in rotation order takes it. After reset, and whenever nobody is asking, the grant rests on the primary device. The secondary's request arrives active-low from another device, so it is retimed through a flop synchroniser before arbitration. A mode input marks unmanaged operation. In that mode the CPU can still win the bus, but its grant is also flagged as a debug-only grant.

Top module: `bus_master_arbiter`

## Requirements
- R1: While reset is active and in the first cycle after it is released, only the primary grant is high, and `secCsN` is high.
- R2: No more than one of `cpuGnt`, `priGntInt` and `secGnt` is high in any cycle.
- R3: `secCsN` is low exactly in the cycles where `secGnt` is high, so both change on the same clock edge. A primary or CPU grant never pulls `secCsN` low.
- R4: A granted owner keeps its grant on every edge at which its request, as seen by the arbiter, is still asserted.
- R5: When the owner's request is seen low, the grant is removed on that edge and every grant stays low for one full cycle. One edge later a new grant is issued, unless the primary holds the bus parked (R7).
- R6: At the end of the idle cycle, the new owner is the first pending requester that follows the last owner in the cyclic order primary (index 0), secondary (index 1), CPU (index 2). The last owner itself comes last.
- R7: If nobody is requesting at the end of an idle cycle, the primary is granted. A primary grant that has no request stays in place until some other request is seen.
- R8: `secReqN` is active-low and passes through SYNC_STAGES flops (2 by default). With the primary parked, a low level applied just after an edge releases the primary on the third edge and raises `secGnt` on the fourth. A high level takes effect equally late.
- R9: The CPU is granted under the same rules whether or not `unmanagedMode` is high. `cpuDbgGnt` is high exactly while `cpuGnt` is high for a grant issued on an edge at which `unmanagedMode` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| unmanagedMode | input | 1 | High when the system runs unmanaged; CPU grants are then debug grants |
| cpuReq | input | 1 | CPU bus request, active high |
| priReq | input | 1 | Primary device request, active high, local |
| secReqN | input | 1 | Secondary device request, active low, asynchronous |
| cpuGnt | output | 1 | Grant to the CPU |
| cpuDbgGnt | output | 1 | Marks the current CPU grant as debug-only |
| priGntInt | output | 1 | Internal grant to the primary's bus master state machine |
| secGnt | output | 1 | External grant to the secondary device |
| secCsN | output | 1 | Chip-select to the secondary device, active low |

## Verification
A corrupted owner register shows up on the first edge after it happens: the wrong grant line goes high. If the corruption falls in an idle cycle, the next rotation picks the wrong requester. A stuck granted/idle flag shows up as a grant that never returns after a release, or as a release with no idle cycle. Either one differs from the bench's cycle-level model on the next falling edge. A synchroniser with the wrong depth moves every secondary grant and release by whole cycles, and the fixed four-edge latency check on `secGnt` catches this.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam int unsigned NUM_MASTERS = 3;

  // Rotation order is behaviour: primary, then secondary, then CPU.
  typedef enum logic [1:0] {
    MST_PRI = 2'd0,
    MST_SEC = 2'd1,
    MST_CPU = 2'd2
  } master_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic granted;  // a grant is presented this cycle
    logic issue;    // load a new owner on the coming edge
  } arbStrobe_t;

endpackage

// File: rtl/arb_control.sv
module arb_control
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ownerReq,
  input  logic       anyOtherReq,
  input  logic       ownerIsPri,
  output arbStrobe_t strobe
);

  logic granted;
  logic releaseNow;

  // Release when the owner stops asking, except for a parked primary
  // with nobody else waiting.
  always_comb begin
    releaseNow = granted && !ownerReq && !(ownerIsPri && !anyOtherReq);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      granted <= 1'b1;
    end else if (granted) begin
      granted <= !releaseNow;
    end else begin
      granted <= 1'b1;
    end
  end

  always_comb begin
    strobe.granted = granted;
    strobe.issue   = !granted;
  end

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       unmanagedMode,
  input  logic       cpuReq,
  input  logic       priReq,
  input  logic       secReqN,
  input  arbStrobe_t strobe,
  output logic       ownerReq,
  output logic       anyOtherReq,
  output logic       ownerIsPri,
  output logic       cpuGnt,
  output logic       cpuDbgGnt,
  output logic       priGntInt,
  output logic       secGnt,
  output logic       secCsN
);

  logic [SYNC_STAGES-1:0] secSync;
  logic [NUM_MASTERS-1:0] reqVec;
  logic [NUM_MASTERS-1:0] ownerMask;
  logic [NUM_MASTERS-1:0] gntVec;
  master_e                owner;
  master_e                nextOwner;
  logic                   dbgFlag;

  // Retiming chain for the remote request, stored active high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) secSync[0] <= 1'b0;
    else       secSync[0] <= ~secReqN;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) secSync[s] <= 1'b0;
      else       secSync[s] <= secSync[s-1];
    end
  end

  always_comb begin
    reqVec          = '0;
    reqVec[MST_PRI] = priReq;
    reqVec[MST_SEC] = secSync[SYNC_STAGES-1];
    reqVec[MST_CPU] = cpuReq;
    ownerMask        = '0;
    ownerMask[owner] = 1'b1;
    ownerReq    = reqVec[owner];
    anyOtherReq = |(reqVec & ~ownerMask);
    ownerIsPri  = (owner == MST_PRI);
  end

  // Rotation: scan from the requester after the last owner.
  always_comb begin
    logic found;
    int   idx;
    found     = 1'b0;
    nextOwner = MST_PRI;
    for (int k = 1; k <= int'(NUM_MASTERS); k++) begin
      idx = (int'(owner) + k) % int'(NUM_MASTERS);
      if (!found && reqVec[idx]) begin
        found     = 1'b1;
        nextOwner = master_e'(idx[1:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owner   <= MST_PRI;
      dbgFlag <= 1'b0;
    end else if (strobe.issue) begin
      owner   <= nextOwner;
      dbgFlag <= unmanagedMode && (nextOwner == MST_CPU);
    end
  end

  always_comb begin
    gntVec    = strobe.granted ? ownerMask : '0;
    cpuGnt    = gntVec[MST_CPU];
    priGntInt = gntVec[MST_PRI];
    secGnt    = gntVec[MST_SEC];
    secCsN    = ~gntVec[MST_SEC];
    cpuDbgGnt = gntVec[MST_CPU] && dbgFlag;
  end

endmodule

// File: rtl/bus_master_arbiter.sv
module bus_master_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic unmanagedMode,
  input  logic cpuReq,
  input  logic priReq,
  input  logic secReqN,
  output logic cpuGnt,
  output logic cpuDbgGnt,
  output logic priGntInt,
  output logic secGnt,
  output logic secCsN
);

  arbStrobe_t strobe;
  logic       ownerReq;
  logic       anyOtherReq;
  logic       ownerIsPri;

  arb_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .ownerReq    (ownerReq),
    .anyOtherReq (anyOtherReq),
    .ownerIsPri  (ownerIsPri),
    .strobe      (strobe)
  );

  arb_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .unmanagedMode (unmanagedMode),
    .cpuReq        (cpuReq),
    .priReq        (priReq),
    .secReqN       (secReqN),
    .strobe        (strobe),
    .ownerReq      (ownerReq),
    .anyOtherReq   (anyOtherReq),
    .ownerIsPri    (ownerIsPri),
    .cpuGnt        (cpuGnt),
    .cpuDbgGnt     (cpuDbgGnt),
    .priGntInt     (priGntInt),
    .secGnt        (secGnt),
    .secCsN        (secCsN)
  );

endmodule

// File: rtl/arb_checker.sv
module arb_checker (
  input logic clk,
  input logic rstN,
  input logic cpuReq,
  input logic priReq,
  input logic cpuGnt,
  input logic cpuDbgGnt,
  input logic priGntInt,
  input logic secGnt,
  input logic secCsN
);

  logic anyGnt;
  assign anyGnt = cpuGnt || priGntInt || secGnt;

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cpuGnt, priGntInt, secGnt}));

  // R3
  cs_follows_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(secGnt) |-> !secCsN);

  // R3
  cs_follows_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(secGnt) |-> secCsN);

  // R4
  cpu_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuGnt && cpuReq) |=> cpuGnt);

  // R4
  pri_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (priGntInt && priReq) |=> priGntInt);

  // R5
  cpu_release_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuGnt && !cpuReq) |=> !anyGnt);

  // R5
  idle_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyGnt |=> anyGnt);

  // R9
  dbg_with_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuDbgGnt |-> cpuGnt);

endmodule

bind bus_master_arbiter arb_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuReq    (cpuReq),
  .priReq    (priReq),
  .cpuGnt    (cpuGnt),
  .cpuDbgGnt (cpuDbgGnt),
  .priGntInt (priGntInt),
  .secGnt    (secGnt),
  .secCsN    (secCsN)
);

// File: tb/sim_bus_master_arbiter.sv
module sim_bus_master_arbiter;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic unmanagedMode = 1'b0;
  logic cpuReq = 1'b0;
  logic priReq = 1'b0;
  logic secReqN = 1'b1;
  logic cpuGnt, cpuDbgGnt, priGntInt, secGnt, secCsN;

  int checks = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_master_arbiter #(.SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .unmanagedMode(unmanagedMode),
    .cpuReq(cpuReq), .priReq(priReq), .secReqN(secReqN),
    .cpuGnt(cpuGnt), .cpuDbgGnt(cpuDbgGnt), .priGntInt(priGntInt),
    .secGnt(secGnt), .secCsN(secCsN)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: 0 primary, 1 secondary, 2 CPU.
  int  mS0 = 0, mS1 = 0;
  int  mGranted = 1, mOwner = 0, mDbg = 0;

  always @(posedge clk) begin
    int r[3];
    int anyOther, pick;
    if (!rstN) begin
      mS0 = 0; mS1 = 0; mGranted = 1; mOwner = 0; mDbg = 0;
    end else begin
      r[0] = priReq; r[1] = mS1; r[2] = cpuReq;
      anyOther = 0;
      for (int i = 0; i < 3; i++) if (i != mOwner && r[i] != 0) anyOther = 1;
      if (mGranted != 0) begin
        if (r[mOwner] == 0 && !(mOwner == 0 && anyOther == 0)) mGranted = 0;
      end else begin
        pick = -1;
        for (int k = 1; k <= 3; k++)
          if (pick < 0 && r[(mOwner + k) % 3] != 0) pick = (mOwner + k) % 3;
        if (pick < 0) pick = 0;
        mOwner = pick;
        mDbg = (unmanagedMode && pick == 2) ? 1 : 0;
        mGranted = 1;
      end
      mS1 = mS0;
      mS0 = secReqN ? 0 : 1;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      int eVec;
      eVec = mGranted ? (1 << mOwner) : 0;
      chk("R6 model grants", {cpuGnt, secGnt, priGntInt}, eVec);
      chk("R3 model chip-select", secCsN, (eVec == 2) ? 0 : 1);
      chk("R9 model debug flag", cpuDbgGnt, (eVec == 4 && mDbg != 0) ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 primary in reset", priGntInt, 1);
    chk("R1 cs high in reset", secCsN, 1);
    rstN = 1'b1;
    chk("R1 primary after reset", {cpuGnt, secGnt, priGntInt}, 1);
    repeat (3) begin
      @(negedge clk);
      chk("R7 parked on primary", {cpuGnt, secGnt, priGntInt}, 1);
    end

    // Secondary latency through the synchroniser
    secReqN = 1'b0;
    @(negedge clk); chk("R8 still primary 1", priGntInt, 1);
    @(negedge clk); chk("R8 still primary 2", {secGnt, priGntInt}, 1);
    @(negedge clk); chk("R5 idle before secondary", {cpuGnt, secGnt, priGntInt}, 0);
    @(negedge clk); chk("R8 secondary granted", secGnt, 1);
    chk("R3 cs low with secondary", secCsN, 0);
    repeat (3) begin
      @(negedge clk); chk("R4 secondary held", secGnt, 1);
    end
    secReqN = 1'b1;
    @(negedge clk); chk("R4 sync delays release 1", secGnt, 1);
    @(negedge clk); chk("R4 sync delays release 2", secGnt, 1);
    @(negedge clk); chk("R5 idle after secondary", {cpuGnt, secGnt, priGntInt}, 0);
    chk("R3 cs high when idle", secCsN, 1);
    @(negedge clk); chk("R7 back to primary", {cpuGnt, secGnt, priGntInt}, 1);

    // Rotation
    cpuReq = 1'b1; priReq = 1'b1;
    @(negedge clk); chk("R4 primary holds with request", priGntInt, 1);
    priReq = 1'b0;
    @(negedge clk); chk("R5 idle after primary", {cpuGnt, secGnt, priGntInt}, 0);
    @(negedge clk); chk("R6 CPU after primary", cpuGnt, 1);
    chk("R9 managed CPU not debug", cpuDbgGnt, 0);
    chk("R3 cs high for CPU", secCsN, 1);
    priReq = 1'b1; secReqN = 1'b0;
    repeat (3) begin
      @(negedge clk); chk("R4 CPU held", cpuGnt, 1);
    end
    cpuReq = 1'b0;
    @(negedge clk); chk("R5 idle after CPU", {cpuGnt, secGnt, priGntInt}, 0);
    @(negedge clk); chk("R6 primary after CPU", {cpuGnt, secGnt, priGntInt}, 1);
    priReq = 1'b0;
    @(negedge clk); chk("R5 idle after primary 2", {cpuGnt, secGnt, priGntInt}, 0);
    @(negedge clk); chk("R6 secondary after primary", {cpuGnt, secGnt, priGntInt}, 2);

    // Unmanaged debug grant
    unmanagedMode = 1'b1; cpuReq = 1'b1; secReqN = 1'b1;
    for (int w = 0; w < 10 && !cpuGnt; w++) @(negedge clk);
    chk("R9 unmanaged CPU granted", cpuGnt, 1);
    chk("R9 unmanaged debug flag", cpuDbgGnt, 1);
    cpuReq = 1'b0; unmanagedMode = 1'b0;

    // Random traffic against the model
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      if ($urandom_range(7) == 0) cpuReq = ~cpuReq;
      if ($urandom_range(7) == 0) priReq = ~priReq;
      if ($urandom_range(7) == 0) secReqN = ~secReqN;
      if ($urandom_range(15) == 0) unmanagedMode = ~unmanagedMode;
      chk("R2 one grant", $countones({cpuGnt, secGnt, priGntInt}) <= 1, 1);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule